// File: doc/BRIEF.md
# Adaptive Receive Threshold Calibrator

This block takes a stream of 10-bit samples of a received analog level. It works out where a slicer should put its decision threshold. Each bit period is covered by a group of four samples. A group is accepted only when its samples agree closely with each other. A noisy group is not thrown away as a whole: the oldest sample is dropped, the rest slide down, and the group is evaluated again once one more sample arrives.

Calibration has two phases. In the first, the block averages the accepted bit levels over a run of sixteen bits at a steady high level. If the level jumps, the run starts again. In the second, it averages eight bits of an all-zero run. The midpoint of the two levels sets a 4-bit threshold code. The measured swing and the saturation state of the high level decide which transimpedance gain the next block should use. After calibration the block counts the samples of one data block. When that block ends, the chosen gain is applied, the done flag drops, and a new calibration begins. A restart request can start over at any time.

Top module: `threshold_calibrator`

## Requirements
- R1: A bit level is the sum of the four samples in a group, shifted right by two (the remainder is dropped).
- R2: A group whose variance is above 900 squared codes is rejected. Variance is the sum of the squared deviations from the group mean, shifted right by two. On rejection the oldest sample is discarded, the other three move down one place, and the group is evaluated again after the next sample.
- R3: During the high phase, once at least one bit has been counted, an accepted bit level more than 102 codes above or below the previous accepted level starts the run again. That level becomes the first bit of the new run.
- R4: The high phase ends after 16 accepted bits in one run. The high level is their sum shifted right by four.
- R5: The low phase then takes 8 accepted bits. The low level is their sum shifted right by three. On the cycle the low level is taken, `calDone` goes to 1.
- R6: `thrCode` becomes (high + low) shifted right by 7, which is bits [9:6] of the midpoint. It changes only when a calibration completes and holds its value otherwise, including across restarts.
- R7: At calibration completion the next gain is chosen only when the high level is at most 102 codes above the low level. It is low gain (1) if the high level is above 820 and high gain (0) otherwise. With a larger swing, the previous choice is kept.
- R8: While `calDone` is 1, each sample strobe counts toward a data block of 288 strobes. On the last strobe, `gainLow` takes the chosen gain, `calDone` returns to 0, and the high phase starts again. `gainLow` changes at no other time.
- R9: `restartReq` clears the calibration progress, the accumulated sum and `calDone`, and returns the block to the high phase. `thrCode`, `gainLow` and the pending gain choice are kept.
- R10: After reset, `thrCode` is 0, `gainLow` is 0 (high gain) and `calDone` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleValid | input | 1 | One-cycle strobe for a new sample; at least 6 clocks between strobes |
| sampleData | input | 10 | Sampled receive level |
| restartReq | input | 1 | Restart calibration from the high phase |
| thrCode | output | 4 | Discrete slicer threshold control |
| gainLow | output | 1 | 1 selects low transimpedance gain, 0 high gain |
| calDone | output | 1 | Calibration complete, data block in progress |

## Verification
The block's state is mostly hidden: window slots, the run counter, the accumulator and the pending gain choice. A fault in any of them appears at the ports only at phase boundaries. A wrong bit count or a missed rejection moves the rising edge of `calDone` by whole sample strobes. A wrong sum or jump decision shows up as a different `thrCode` on that same edge. A wrong gain choice stays invisible for a whole data block, until `gainLow` updates. The bench therefore compares all three outputs with a reference model before every sample strobe. It uses level patterns chosen so that each of these faults changes either the strobe on which `calDone` rises or the code value.

// File: rtl/thrcal_pkg.sv
package thrcal_pkg;

  typedef enum logic [1:0] {
    PH_HIGH = 2'd0,
    PH_LOW  = 2'd1,
    PH_DATA = 2'd2
  } phase_e;

  typedef enum logic [1:0] {
    ST_COLLECT = 2'd0,
    ST_MAC     = 2'd1,
    ST_DECIDE  = 2'd2
  } step_e;

  // strobes from control to datapath, at most a few active per cycle
  typedef struct packed {
    logic loadSample;   // write sampleData into window slot wrIdx
    logic macStart;     // clear the squared-deviation accumulator
    logic macStep;      // add one squared deviation (slot macIdx)
    logic dropOldest;   // rejected group: slide window down one slot
    logic accumulate;   // accepted group: add mean to the level sum
    logic runRestart;   // level jump: sum restarts from this mean
    logic latchHigh;    // high run complete: capture high level
    logic latchLow;     // low run complete: threshold and gain choice
    logic applyGain;    // data block complete: drive pending gain
    logic clearCal;     // restart request
  } ctrl_strb_t;

endpackage

// File: rtl/thrcal_datapath.sv
module thrcal_datapath
  import thrcal_pkg::*;
#(
  parameter int SAMPLE_W  = 10,
  parameter int OS_RATIO  = 4,
  parameter int HIGH_BITS = 16,
  parameter int LOW_BITS  = 8,
  parameter int VAR_LIMIT = 900,
  parameter int MIN_SWING = 102,
  parameter int SAT_LEVEL = 820,
  parameter int THR_W     = 4,
  localparam int OS_LOG   = $clog2(OS_RATIO),
  localparam int IDX_W    = (OS_LOG > 0) ? OS_LOG : 1
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrl_strb_t          strb,
  input  logic [IDX_W-1:0]    wrIdx,
  input  logic [IDX_W-1:0]    macIdx,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                varTooBig,
  output logic                levelJump,
  output logic [THR_W-1:0]    thrCode,
  output logic                gainLow
);

  localparam int HIGH_LOG = $clog2(HIGH_BITS);
  localparam int LOW_LOG  = $clog2(LOW_BITS);
  localparam int ACC_W    = SAMPLE_W + HIGH_LOG + 1;
  localparam int SUM_W    = SAMPLE_W + OS_LOG;
  localparam int DIFF_W   = SAMPLE_W + 1;
  localparam int SQ_W     = 2 * DIFF_W;
  localparam int VAR_W    = SQ_W + OS_LOG;
  localparam int THR_SH   = 1 + SAMPLE_W - THR_W;

  logic [SAMPLE_W-1:0] win [OS_RATIO];

  // sample window, one register per slot
  for (genvar g = 0; g < OS_RATIO; g++) begin : g_slot
    if (g < OS_RATIO - 1) begin : g_shift
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          win[g] <= '0;
        end else if (strb.loadSample && wrIdx == IDX_W'(g)) begin
          win[g] <= sampleData;
        end else if (strb.dropOldest) begin
          win[g] <= win[g+1];
        end
      end
    end else begin : g_top
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          win[g] <= '0;
        end else if (strb.loadSample && wrIdx == IDX_W'(g)) begin
          win[g] <= sampleData;
        end
      end
    end
  end

  // group mean
  logic [SUM_W-1:0]    groupSum;
  logic [SAMPLE_W-1:0] groupMean;

  always_comb begin
    groupSum = '0;
    for (int i = 0; i < OS_RATIO; i++) begin
      groupSum = groupSum + SUM_W'(win[i]);
    end
    groupMean = SAMPLE_W'(groupSum >> OS_LOG);
  end

  // squared deviation, one slot per cycle
  logic signed [DIFF_W-1:0] dev;
  logic signed [SQ_W-1:0]   devSq;
  logic [VAR_W-1:0]         varAcc;

  always_comb begin
    dev   = $signed({1'b0, win[macIdx]}) - $signed({1'b0, groupMean});
    devSq = SQ_W'(dev) * SQ_W'(dev);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      varAcc <= '0;
    end else if (strb.macStart) begin
      varAcc <= '0;
    end else if (strb.macStep) begin
      varAcc <= varAcc + VAR_W'($unsigned(devSq));
    end
  end

  assign varTooBig = (varAcc >> OS_LOG) > VAR_W'(VAR_LIMIT);

  // level jump against previous accepted mean
  logic [SAMPLE_W-1:0] prevMean;

  assign levelJump = ({1'b0, groupMean} > {1'b0, prevMean} + (SAMPLE_W+1)'(MIN_SWING)) ||
                     ({1'b0, groupMean} + (SAMPLE_W+1)'(MIN_SWING) < {1'b0, prevMean});

  // level accumulation
  logic [ACC_W-1:0]    levelAcc;
  logic [ACC_W-1:0]    accNext;
  logic [SAMPLE_W-1:0] highLvl;
  logic [SAMPLE_W-1:0] lowNext;
  logic [SAMPLE_W:0]   midSum;
  logic                swingSmall;
  logic                saturated;
  logic                gainNext;

  always_comb begin
    accNext    = levelAcc + ACC_W'(groupMean);
    lowNext    = SAMPLE_W'(accNext >> LOW_LOG);
    midSum     = {1'b0, highLvl} + {1'b0, lowNext};
    swingSmall = {1'b0, highLvl} <= {1'b0, lowNext} + (SAMPLE_W+1)'(MIN_SWING);
    saturated  = highLvl > SAMPLE_W'(SAT_LEVEL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      levelAcc <= '0;
      prevMean <= '0;
      highLvl  <= '0;
    end else if (strb.clearCal) begin
      levelAcc <= '0;
      highLvl  <= '0;
    end else if (strb.accumulate) begin
      prevMean <= groupMean;
      if (strb.runRestart) begin
        levelAcc <= ACC_W'(groupMean);
      end else if (strb.latchHigh || strb.latchLow) begin
        levelAcc <= '0;
      end else begin
        levelAcc <= accNext;
      end
      if (strb.latchHigh) begin
        highLvl <= SAMPLE_W'(accNext >> HIGH_LOG);
      end
    end
  end

  // threshold code and gain choice
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrCode  <= '0;
      gainNext <= 1'b0;
      gainLow  <= 1'b0;
    end else begin
      if (strb.accumulate && strb.latchLow) begin
        thrCode <= THR_W'(midSum >> THR_SH);
        if (swingSmall) begin
          gainNext <= saturated;
        end
      end
      if (strb.applyGain) begin
        gainLow <= gainNext;
      end
    end
  end

endmodule

// File: rtl/thrcal_ctrl.sv
module thrcal_ctrl
  import thrcal_pkg::*;
#(
  parameter int OS_RATIO     = 4,
  parameter int HIGH_BITS    = 16,
  parameter int LOW_BITS     = 8,
  parameter int DATA_SAMPLES = 288,
  localparam int OS_LOG      = $clog2(OS_RATIO),
  localparam int IDX_W       = (OS_LOG > 0) ? OS_LOG : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             sampleValid,
  input  logic             restartReq,
  input  logic             varTooBig,
  input  logic             levelJump,
  output ctrl_strb_t       strb,
  output logic [IDX_W-1:0] wrIdx,
  output logic [IDX_W-1:0] macIdx,
  output logic             calDone
);

  localparam int BCNT_W = $clog2(HIGH_BITS + 1);
  localparam int DCNT_W = $clog2(DATA_SAMPLES + 1);
  localparam logic [IDX_W-1:0] LAST_SLOT = IDX_W'(OS_RATIO - 1);

  phase_e            phase;
  step_e             step;
  logic [IDX_W-1:0]  winCnt;
  logic [BCNT_W-1:0] bitCnt;
  logic [DCNT_W-1:0] dataCnt;
  logic              blockEnd;

  assign wrIdx    = winCnt;
  assign calDone  = (phase == PH_DATA);
  assign blockEnd = (dataCnt == DCNT_W'(DATA_SAMPLES - 1));

  always_comb begin
    strb = '0;
    if (restartReq) begin
      strb.clearCal = 1'b1;
    end else begin
      unique case (step)
        ST_COLLECT: begin
          if (sampleValid) begin
            if (phase == PH_DATA) begin
              strb.applyGain = blockEnd;
            end else begin
              strb.loadSample = 1'b1;
              strb.macStart   = (winCnt == LAST_SLOT);
            end
          end
        end
        ST_MAC: strb.macStep = 1'b1;
        ST_DECIDE: begin
          if (varTooBig) begin
            strb.dropOldest = 1'b1;
          end else begin
            strb.accumulate = 1'b1;
            if (phase == PH_HIGH) begin
              strb.runRestart = levelJump && (bitCnt != '0);
              strb.latchHigh  = !strb.runRestart && (bitCnt == BCNT_W'(HIGH_BITS - 1));
            end else begin
              strb.latchLow = (bitCnt == BCNT_W'(LOW_BITS - 1));
            end
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_HIGH;
      step    <= ST_COLLECT;
      winCnt  <= '0;
      macIdx  <= '0;
      bitCnt  <= '0;
      dataCnt <= '0;
    end else if (restartReq) begin
      phase   <= PH_HIGH;
      step    <= ST_COLLECT;
      winCnt  <= '0;
      macIdx  <= '0;
      bitCnt  <= '0;
      dataCnt <= '0;
    end else begin
      unique case (step)
        ST_COLLECT: begin
          if (sampleValid) begin
            if (phase == PH_DATA) begin
              if (blockEnd) begin
                dataCnt <= '0;
                phase   <= PH_HIGH;
                bitCnt  <= '0;
              end else begin
                dataCnt <= dataCnt + 1'b1;
              end
            end else if (winCnt == LAST_SLOT) begin
              step   <= ST_MAC;
              macIdx <= '0;
            end else begin
              winCnt <= winCnt + 1'b1;
            end
          end
        end
        ST_MAC: begin
          macIdx <= macIdx + 1'b1;
          if (macIdx == LAST_SLOT) begin
            step <= ST_DECIDE;
          end
        end
        ST_DECIDE: begin
          step <= ST_COLLECT;
          if (varTooBig) begin
            winCnt <= LAST_SLOT;
          end else begin
            winCnt <= '0;
            if (strb.runRestart) begin
              bitCnt <= BCNT_W'(1);
            end else if (strb.latchHigh) begin
              bitCnt <= '0;
              phase  <= PH_LOW;
            end else if (strb.latchLow) begin
              bitCnt  <= '0;
              dataCnt <= '0;
              phase   <= PH_DATA;
            end else begin
              bitCnt <= bitCnt + 1'b1;
            end
          end
        end
        default: step <= ST_COLLECT;
      endcase
    end
  end

endmodule

// File: rtl/threshold_calibrator.sv
module threshold_calibrator
  import thrcal_pkg::*;
#(
  parameter int SAMPLE_W     = 10,
  parameter int OS_RATIO     = 4,
  parameter int HIGH_BITS    = 16,
  parameter int LOW_BITS     = 8,
  parameter int VAR_LIMIT    = 900,
  parameter int MIN_SWING    = 102,
  parameter int SAT_LEVEL    = 820,
  parameter int THR_W        = 4,
  parameter int DATA_SAMPLES = 288
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  input  logic                restartReq,
  output logic [THR_W-1:0]    thrCode,
  output logic                gainLow,
  output logic                calDone
);

  localparam int OS_LOG = $clog2(OS_RATIO);
  localparam int IDX_W  = (OS_LOG > 0) ? OS_LOG : 1;

  ctrl_strb_t       strb;
  logic [IDX_W-1:0] wrIdx;
  logic [IDX_W-1:0] macIdx;
  logic             varTooBig;
  logic             levelJump;

  thrcal_ctrl #(
    .OS_RATIO    (OS_RATIO),
    .HIGH_BITS   (HIGH_BITS),
    .LOW_BITS    (LOW_BITS),
    .DATA_SAMPLES(DATA_SAMPLES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .restartReq (restartReq),
    .varTooBig  (varTooBig),
    .levelJump  (levelJump),
    .strb       (strb),
    .wrIdx      (wrIdx),
    .macIdx     (macIdx),
    .calDone    (calDone)
  );

  thrcal_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .OS_RATIO (OS_RATIO),
    .HIGH_BITS(HIGH_BITS),
    .LOW_BITS (LOW_BITS),
    .VAR_LIMIT(VAR_LIMIT),
    .MIN_SWING(MIN_SWING),
    .SAT_LEVEL(SAT_LEVEL),
    .THR_W    (THR_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .wrIdx     (wrIdx),
    .macIdx    (macIdx),
    .sampleData(sampleData),
    .varTooBig (varTooBig),
    .levelJump (levelJump),
    .thrCode   (thrCode),
    .gainLow   (gainLow)
  );

endmodule

// File: rtl/thrcal_checker.sv
module thrcal_checker #(
  parameter int THR_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic             sampleValid,
  input logic             restartReq,
  input logic [THR_W-1:0] thrCode,
  input logic             gainLow,
  input logic             calDone
);

  // R6: the code moves only on the edge where calibration completes
  assert_thr_on_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(thrCode) |-> $rose(calDone));

  // R8: gain output moves only when a data block closes
  assert_gain_at_block_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(gainLow) |-> $fell(calDone));

  // R8: without a strobe or restart the done flag holds
  assert_done_holds_R8: assert property (@(posedge clk) disable iff (!rstN)
    (calDone && !sampleValid && !restartReq) |=> calDone);

  // R9: a restart always leaves the block not calibrated
  assert_restart_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    restartReq |=> !calDone);

  // R5: completion never coincides with a restart
  assert_done_not_on_restart_R5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(calDone) |-> !$past(restartReq));

endmodule

bind threshold_calibrator thrcal_checker #(.THR_W(THR_W)) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .sampleValid(sampleValid),
  .restartReq (restartReq),
  .thrCode    (thrCode),
  .gainLow    (gainLow),
  .calDone    (calDone)
);

// File: tb/threshold_calibrator_bench.sv
module threshold_calibrator_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DATA_LEN   = 288;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       sampleValid = 1'b0;
  logic [9:0] sampleData = '0;
  logic       restartReq = 1'b0;
  logic [3:0] thrCode;
  logic       gainLow;
  logic       calDone;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  threshold_calibrator u_threshold_calibrator (
    .clk        (clk),
    .rstN       (rstN),
    .sampleValid(sampleValid),
    .sampleData (sampleData),
    .restartReq (restartReq),
    .thrCode    (thrCode),
    .gainLow    (gainLow),
    .calDone    (calDone)
  );

  // behavioural reference model
  int mWin[$];
  int mPhase = 0;      // 0 high, 1 low, 2 data
  int mBits = 0;
  int mAcc = 0;
  int mPrev = 0;
  int mHigh = 0;
  int mThr = 0;
  int mGainNext = 0;
  int mGain = 0;
  int mDone = 0;
  int mData = 0;

  function automatic void modelAccept(int mean);
    if (mPhase == 0) begin
      if (mBits > 0 && (mean > mPrev + 102 || mean + 102 < mPrev)) begin
        mBits = 0;
        mAcc = 0;
      end
      mAcc += mean;
      mPrev = mean;
      mBits++;
      if (mBits == 16) begin
        mHigh = mAcc >> 4;
        mAcc = 0;
        mBits = 0;
        mPhase = 1;
      end
    end else begin
      mAcc += mean;
      mPrev = mean;
      mBits++;
      if (mBits == 8) begin
        int low;
        low = mAcc >> 3;
        mThr = ((mHigh + low) >> 1) >> 6;
        if (mHigh <= low + 102) mGainNext = (mHigh > 820) ? 1 : 0;
        mDone = 1;
        mPhase = 2;
        mAcc = 0;
        mBits = 0;
        mData = 0;
      end
    end
  endfunction

  function automatic void modelStrobe(int v);
    if (mPhase == 2) begin
      mData++;
      if (mData == DATA_LEN) begin
        mData = 0;
        mGain = mGainNext;
        mDone = 0;
        mPhase = 0;
        mBits = 0;
      end
    end else begin
      mWin.push_back(v);
      if (mWin.size() == 4) begin
        int sum;
        int mean;
        int var4;
        sum = 0;
        foreach (mWin[i]) sum += mWin[i];
        mean = sum >> 2;
        var4 = 0;
        foreach (mWin[i]) var4 += (mWin[i] - mean) * (mWin[i] - mean);
        if ((var4 >> 2) > 900) begin
          void'(mWin.pop_front());
        end else begin
          mWin.delete();
          modelAccept(mean);
        end
      end
    end
  endfunction

  function automatic void modelRestart();
    mWin.delete();
    mPhase = 0;
    mBits = 0;
    mAcc = 0;
    mHigh = 0;
    mDone = 0;
    mData = 0;
  endfunction

  task automatic expectVal(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compareAll(string req);
    expectVal(req, "thrCode", int'(thrCode), mThr);
    expectVal(req, "gainLow", int'(gainLow), mGain);
    expectVal(req, "calDone", int'(calDone), mDone);
  endtask

  // outputs are settled: last strobe is at least 7 cycles back
  task automatic sendSample(int v, string req);
    compareAll(req);
    sampleData  = 10'(v);
    sampleValid = 1'b1;
    modelStrobe(v);
    @(negedge clk);
    sampleValid = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // each bit: four samples whose sum is exactly four times the level
  task automatic sendBits(int level, int n, string req);
    for (int b = 0; b < n; b++) begin
      sendSample(level, req);
      sendSample(level + 2, req);
      sendSample(level - 2, req);
      sendSample(level, req);
    end
  endtask

  task automatic sendData(int n, string req);
    for (int k = 0; k < n; k++) sendSample((k % 2 == 0) ? 900 : 40, req);
  endtask

  task automatic doRestart();
    @(negedge clk);
    restartReq = 1'b1;
    @(negedge clk);
    restartReq = 1'b0;
    modelRestart();
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    $display("FAIL R8 watchdog: actual=running expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    expectVal("R10", "thrCode", int'(thrCode), 0);
    expectVal("R10", "gainLow", int'(gainLow), 0);
    expectVal("R10", "calDone", int'(calDone), 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // first calibration: short run at 300, noisy group, then 800 run
    sendBits(300, 4, "R3");
    sendSample(800, "R2");
    sendSample(0, "R2");
    sendSample(800, "R2");
    sendSample(800, "R2");   // mean 600, rejected
    sendSample(800, "R2");   // still holds the 0, rejected
    sendSample(800, "R2");   // accepted: jump, first bit of new run
    sendBits(800, 14, "R4");
    compareAll("R4");
    expectVal("R3", "calDone after 15 bits of new run", int'(calDone), 0);
    sendBits(800, 1, "R4");
    // low run: one group with remainder dropped (403 -> 100)
    sendSample(101, "R1");
    sendSample(102, "R1");
    sendSample(100, "R1");
    sendSample(100, "R1");
    sendBits(100, 6, "R5");
    compareAll("R5");
    expectVal("R5", "calDone before last low bit", int'(calDone), 0);
    sendBits(100, 1, "R5");
    compareAll("R5");
    expectVal("R5", "calDone", int'(calDone), 1);
    expectVal("R1", "thrCode (800+100)>>7", int'(thrCode), 7);

    // data block, large swing keeps high gain
    sendData(DATA_LEN - 1, "R8");
    compareAll("R8");
    expectVal("R8", "calDone before block end", int'(calDone), 1);
    sendData(1, "R8");
    compareAll("R8");
    expectVal("R8", "calDone after block", int'(calDone), 0);
    expectVal("R7", "gainLow large swing", int'(gainLow), 0);

    // second calibration: small swing with saturated high level
    sendBits(900, 16, "R4");
    sendBits(850, 8, "R7");
    compareAll("R7");
    expectVal("R6", "thrCode (900+850)>>7", int'(thrCode), 13);
    expectVal("R8", "gainLow not yet applied", int'(gainLow), 0);
    sendData(DATA_LEN, "R8");
    compareAll("R8");
    expectVal("R7", "gainLow saturated", int'(gainLow), 1);

    // restart in the middle of the high run
    sendBits(500, 10, "R9");
    doRestart();
    compareAll("R9");
    expectVal("R9", "calDone after restart", int'(calDone), 0);
    expectVal("R6", "thrCode kept over restart", int'(thrCode), 13);
    sendBits(500, 16, "R9");
    compareAll("R9");
    expectVal("R9", "calDone after fresh high run", int'(calDone), 0);
    sendBits(450, 8, "R7");
    compareAll("R7");
    expectVal("R6", "thrCode (500+450)>>7", int'(thrCode), 7);
    expectVal("R5", "calDone", int'(calDone), 1);

    // restart during the data block: pending gain not applied
    sendData(100, "R8");
    doRestart();
    compareAll("R9");
    expectVal("R9", "gainLow kept on restart", int'(gainLow), 1);
    expectVal("R9", "calDone", int'(calDone), 0);
    sendBits(500, 16, "R4");
    sendBits(450, 8, "R5");
    sendData(DATA_LEN, "R8");
    compareAll("R8");
    expectVal("R7", "gainLow small swing unsaturated", int'(gainLow), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule